// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is a reconfigurable two-level logic plane. Dedicated inputs and fed-back signals enter in pairs. Each signal produces two literals: its true value and its inverse. Every AND term holds one connection bit per literal. The term is the product of the literals whose bit is set. The AND terms are split into equal consecutive groups, and each group is OR-ed into one logic output. A fixed set of configuration bits therefore gives a two-level function of all signals, and writing new bits gives a different function.

The connection bits sit in registers and are loaded through a one-bit memory-style write port. The port has an address, a data bit, a write strobe and a programming-mode enable. The connection bits of one term form one row of consecutive addresses, and term t's row begins at t times the row length. While programming mode is on, the logic outputs are held at 0. A typical use is to hold the block in programming mode, write each bit to be connected, then release the mode and use the outputs as combinational logic.

Top module: `pla_array`

## Requirements
- R1: A synchronous reset clears every connection bit, so all outputs read 0 for any input value once reset has been applied.
- R2: Within a term's row of 4*N_PAIR addresses (row t starts at address t*4*N_PAIR), dedicated input k uses column 4k for its true value and 4k+1 for its inverse, and fed-back signal k uses column 4k+2 for its true value and 4k+3 for its inverse.
- R3: An AND term is 1 exactly when every literal connected to it is 1. A stored 1 means connected.
- R4: A term with no connected literals evaluates to 0.
- R5: A term that connects both the true value and the inverse of the same signal evaluates to 0 for every input.
- R6: Output o is the OR of terms o*TERMS_PER_OUT through o*TERMS_PER_OUT+TERMS_PER_OUT-1.
- R7: A write changes a connection bit on the next rising clock edge only if prog_en and wr_en are both 1. Otherwise the stored bits stay unchanged.
- R8: While prog_en is 1, every logic output is 0.
- R9: A write to an address at or above N_TERM*4*N_PAIR has no effect on any connection bit.
- R10: Writing a 0 to a connected location disconnects that literal, so a term can be reprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset; disconnects every literal |
| prog_en | input | 1 | Programming mode; enables writes and forces the outputs to 0 |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | ADDR_W (6) | Linear address of one connection bit |
| wr_data | input | 1 | Connection bit value: 1 connected, 0 open |
| ded_in | input | N_PAIR (3) | Dedicated logic inputs |
| fb_in | input | N_PAIR (3) | Fed-back signals from outside the plane |
| f_out | output | N_OUT (2) | Sum-of-products logic outputs |

## Verification
The bench programs a small function across three terms and then walks several input patterns. If the true and inverse columns were swapped, or the fed-back columns were placed at the wrong stride, the walk would give wrong outputs. An empty term is tested because a design that builds the AND only from the mask would output 1 for a term with nothing connected. A term that connects a signal and its inverse must stay at 0. A design that reduced the literals incorrectly could let that term fire.

Writes made without the strobe or outside programming mode are aimed at a term whose change would show on an output. An address beyond the array is also written, to catch address decoding that wraps around. The outputs are checked to be 0 during programming mode, and a bit is cleared back to 0 to show that a term can be rewritten.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic {
        LIT_TRUE = 1'b0,
        LIT_COMP = 1'b1
    } lit_kind_e;

    typedef struct packed {
        logic strobe;
        logic data;
    } cfg_wr_t;

    // column of a literal within one term row: pair stride is 4
    function automatic int unsigned lit_col(int unsigned pair, logic is_fb, lit_kind_e kind);
        return 4 * pair + 2 * int'(is_fb) + int'(kind);
    endfunction

endpackage

// File: rtl/pla_literals.sv
module pla_literals
    import pla_pkg::*;
#(
    parameter int N_PAIR = 3,
    localparam int ROW = 4 * N_PAIR
) (
    input  logic [N_PAIR-1:0] ded_in,
    input  logic [N_PAIR-1:0] fb_in,
    output logic [ROW-1:0]    lit
);

    for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
        assign lit[lit_col(k, 1'b0, LIT_TRUE)] = ded_in[k];
        assign lit[lit_col(k, 1'b0, LIT_COMP)] = ~ded_in[k];
        assign lit[lit_col(k, 1'b1, LIT_TRUE)] = fb_in[k];
        assign lit[lit_col(k, 1'b1, LIT_COMP)] = ~fb_in[k];
    end

endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int N_TERM = 4,
    parameter int ROW    = 12,
    parameter int ADDR_W = 6,
    localparam int TOTAL = N_TERM * ROW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    output logic [TOTAL-1:0]  cfg
);

    cfg_wr_t req;
    logic    in_range;

    always_comb begin
        in_range   = int'(wr_addr) < TOTAL;
        req.strobe = prog_en && wr_en && in_range;
        req.data   = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (req.strobe) begin
            cfg[int'(wr_addr)] <= req.data;
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> cfg == '0);

    // R7
    no_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(prog_en && wr_en) |=> $stable(cfg));

    // R9
    oob_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_en && wr_en && int'(wr_addr) >= TOTAL) |=> $stable(cfg));

    // R7
    wr_land_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_en && wr_en && int'(wr_addr) < TOTAL) |=> cfg[int'($past(wr_addr))] == $past(wr_data));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_TERM = 4,
    parameter int ROW    = 12
) (
    input  logic [ROW-1:0]        lit,
    input  logic [N_TERM*ROW-1:0] cfg,
    output logic [N_TERM-1:0]     term
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [ROW-1:0] mask;
        assign mask    = cfg[t*ROW +: ROW];
        // empty term is forced low; otherwise all connected literals must be high
        assign term[t] = (|mask) & (&(~mask | lit));
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_OUT         = 2,
    parameter int TERMS_PER_OUT = 2,
    localparam int N_TERM       = N_OUT * TERMS_PER_OUT
) (
    input  logic [N_TERM-1:0] term,
    input  logic              quiet,
    output logic [N_OUT-1:0]  f
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign f[o] = ~quiet & (|term[o*TERMS_PER_OUT +: TERMS_PER_OUT]);
    end

endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_PAIR        = 3,
    parameter int TERMS_PER_OUT = 2,
    parameter int N_OUT         = 2,
    localparam int ROW          = 4 * N_PAIR,
    localparam int N_TERM       = N_OUT * TERMS_PER_OUT,
    localparam int TOTAL        = N_TERM * ROW,
    localparam int ADDR_W       = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_data,
    input  logic [N_PAIR-1:0] ded_in,
    input  logic [N_PAIR-1:0] fb_in,
    output logic [N_OUT-1:0]  f_out
);

    logic [ROW-1:0]    lit;
    logic [TOTAL-1:0]  cfg;
    logic [N_TERM-1:0] term;

    pla_literals #(.N_PAIR(N_PAIR)) u_lit (
        .ded_in (ded_in),
        .fb_in  (fb_in),
        .lit    (lit)
    );

    pla_cfg_store #(.N_TERM(N_TERM), .ROW(ROW), .ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .prog_en (prog_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    pla_and_plane #(.N_TERM(N_TERM), .ROW(ROW)) u_and (
        .lit  (lit),
        .cfg  (cfg),
        .term (term)
    );

    pla_or_plane #(.N_OUT(N_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)) u_or (
        .term  (term),
        .quiet (prog_en),
        .f     (f_out)
    );

    // R8
    prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> f_out == '0);

    // R6
    out_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
        (|f_out) |-> (|term));

    for (genvar t = 0; t < N_TERM; t++) begin : g_chk
        // R4
        empty_term_low_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg[t*ROW +: ROW] == '0) |-> !term[t]);
    end

endmodule

// File: tb/pla_array_bench.sv
module pla_array_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic       wr_data = 1'b0;
    logic [2:0] ded_in = '0;
    logic [2:0] fb_in = '0;
    logic [1:0] f_out;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pla_array u_pla_array (
        .clk(clk), .rst(rst), .prog_en(prog_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .ded_in(ded_in), .fb_in(fb_in), .f_out(f_out)
    );

    // {ded[2:0], fb[2:0], expected {f1,f0}}
    // f0 = d0&~d1 | f2 ; f1 = d1&f0 (term 3 empty)
    localparam logic [7:0] VEC [8] = '{
        8'b000_000_00, 8'b001_000_01, 8'b011_000_00, 8'b010_001_10,
        8'b011_101_11, 8'b000_100_01, 8'b111_011_10, 8'b101_010_01
    };

    task automatic check(input string req, input logic [1:0] exp);
        n_run++;
        if (f_out !== exp) begin
            n_fail++;
            $display("FAIL %s: f_out=%b expected=%b", req, f_out, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic d);
        @(negedge clk);
        prog_en = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_mode();
        @(negedge clk);
        prog_en = 1'b0;
        #1;
    endtask

    task automatic apply(input logic [2:0] d, input logic [2:0] f);
        ded_in = d; fb_in = f; #1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: nothing connected after reset
        apply(3'b111, 3'b111); check("R1", 2'b00);
        apply(3'b000, 3'b000); check("R1", 2'b00);

        // R2 addresses: term0 d0 true=0, d1 comp=5; term1 fb2 true=22;
        // term2 d1 true=28, fb0 true=26
        cfg_write(6'd0, 1'b1);
        cfg_write(6'd5, 1'b1);
        cfg_write(6'd22, 1'b1);
        cfg_write(6'd28, 1'b1);
        cfg_write(6'd26, 1'b1);
        // R8: outputs forced low in programming mode
        apply(3'b001, 3'b100); check("R8", 2'b00);
        run_mode();

        // R2 R3 R6 R4: table walk
        for (int i = 0; i < 8; i++) begin
            apply(VEC[i][7:5], VEC[i][4:2]);
            check("R2/R3/R6", VEC[i][1:0]);
        end

        // R7: write to term3 d0 true (36) with prog_en low
        @(negedge clk);
        prog_en = 1'b0; wr_en = 1'b1; wr_addr = 6'd36; wr_data = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        apply(3'b001, 3'b000); check("R7", 2'b01);
        // R7: strobe low in programming mode
        @(negedge clk);
        prog_en = 1'b1; wr_en = 1'b0; wr_addr = 6'd36; wr_data = 1'b1;
        run_mode();
        apply(3'b001, 3'b000); check("R7", 2'b01);

        // R9: out-of-range addresses
        cfg_write(6'd48, 1'b1);
        cfg_write(6'd60, 1'b1);
        cfg_write(6'd63, 1'b1);
        run_mode();
        apply(3'b001, 3'b000); check("R9", 2'b01);
        apply(3'b000, 3'b000); check("R9", 2'b00);

        // R3: term3 gets d0 true only -> f1 = d0 | d1&f0
        cfg_write(6'd36, 1'b1);
        run_mode();
        apply(3'b001, 3'b000); check("R3", 2'b11);

        // R5: add d0 complement -> term3 dead
        cfg_write(6'd37, 1'b1);
        run_mode();
        apply(3'b001, 3'b000); check("R5", 2'b01);
        apply(3'b000, 3'b000); check("R5", 2'b00);

        // R10: clear d0 true -> term3 = ~d0
        cfg_write(6'd36, 1'b0);
        run_mode();
        apply(3'b000, 3'b000); check("R10", 2'b10);
        apply(3'b001, 3'b000); check("R10", 2'b01);

        // R1: reset again wipes the function
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        apply(3'b000, 3'b100); check("R1", 2'b00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #4_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule